// File: doc/BRIEF.md
# Single-Line Serial Bus Host

This block is a memory-mapped host for a one-wire serial bus: one open-drain line that carries both timing and data, shared by one host and any number of slave devices. Software loads an instruction word holding a 4-bit opcode and an 8-bit payload. It then sets a start bit in the control register. The block runs one operation on the line: a reset with presence detect, a single-bit read or write, or a byte read or write. Bytes are sent as eight bit slots, least significant bit first.

Each bit slot is timed in microseconds. A divider turns the core clock into a microsecond tick, and the divider restarts at the start of each slot. The host only pulls the line low, through an output enable. The line level comes back through a two-flop synchroniser before it is sampled. Completion and readiness appear in a status register and can raise a level-high interrupt. Received bits land in a data register. Fixed identification and version words let software confirm which block it is talking to.

Software uses the block in this order: wait for ready, write the instruction, set start, wait for done, read any result, then write zero to the control register.

Top module: `owire_host`

## Requirements
- R1: The identification register (offset 0x1C) reads 0x10EE4453. The version register (offset 0x18) reads major version 1 in bits 23:8 and the minor version parameter in bits 7:0.
- R2: After reset the status register (offset 0x0C) reads 0x00000010: ready in bit 4 set, done in bit 0 clear, no-device in bit 31 clear. The line is released and the interrupt is low.
- R3: Opcode 0x8 in instruction bits 11:8 (offset 0x00) runs a reset pulse. The pulse pulls the line low for exactly 480 µs. Status bit 31 then reads 0 if a device pulled the line low during the presence window, and 1 if no device did.
- R4: Opcode 0xE writes the bit in instruction bit 0. A 1 pulls the line low for 6 µs and a 0 pulls it low for 60 µs.
- R5: Opcode 0xC runs a read slot with a 6 µs low pulse. The sampled line level is then in bit 0 of the data register (offset 0x10), and the other data bits are zero.
- R6: Opcode 0xF sends instruction bits 7:0 as eight write slots, bit 0 first.
- R7: Opcode 0xD runs eight read slots. The first bit received lands in data bit 0, and the byte occupies data bits 7:0.
- R8: Writing 1 to control bit 0 (offset 0x04) starts the latched instruction only on a 0-to-1 change. Ready stays low from the start until the start bit is cleared. Done is set when the operation finishes and holds while the start bit stays 1. Writing 0 to control clears done and restores ready.
- R9: The interrupt output is high while (enable bit 0 and done) or (enable bit 4 and ready) holds, using the enable register at offset 0x08. Writing 0 to the enable register drops it by the next cycle.
- R10: Control bit 31 is a soft reset. It releases the line within one cycle, abandons any operation, restores ready, and clears the data register and status bit 31. A start bit written in the same word as the soft reset starts nothing, either then or when the reset is released with the start bit still 1.
- R11: An instruction whose opcode is not one of 0x8, 0xC, 0xD, 0xE, 0xF completes with done set and produces no activity on the line.
- R12: Writes to the instruction register are ignored while ready is low, so a running operation keeps its opcode and payload.
- R13: A register read request (req_valid with req_write low) is answered with rsp_valid high and the data on rsp_rdata in the next cycle. req_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level-high interrupt |
| line_oe | output | 1 | 1 = pull the bus line low |
| line_in | input | 1 | Sensed bus line level |

## Verification
Two pairs of events can land on the same cycle.

The first pair is soft reset and start, which share the control word. The bench writes 0x80000001. It confirms that no slot appears on the line and that ready stays high. It then releases the reset while keeping the start bit at 1, and confirms that still nothing starts.

The second pair is an instruction write and a running byte transfer. The bench writes a new byte instruction while a byte write is in flight. A device model decodes every low pulse by its length in clock cycles. The bench requires the decoded byte to match the original payload, not the new one.

// File: rtl/owh_pkg.sv
package owh_pkg;

  typedef enum logic [1:0] {SK_RESET, SK_WR0, SK_WR1, SK_READ} slot_kind_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PRES, OP_RDBIT, OP_WRBIT, OP_RDBYTE, OP_WRBYTE
  } op_e;

  localparam logic [4:0] A_INSTR = 5'h00;
  localparam logic [4:0] A_CTRL  = 5'h04;
  localparam logic [4:0] A_IEN   = 5'h08;
  localparam logic [4:0] A_STAT  = 5'h0C;
  localparam logic [4:0] A_DATA  = 5'h10;
  localparam logic [4:0] A_VER   = 5'h18;
  localparam logic [4:0] A_ID    = 5'h1C;

  localparam logic [31:0] ID_WORD   = 32'h10EE4453;
  localparam logic [15:0] VER_MAJOR = 16'd1;

  function automatic op_e decode_op(input logic [3:0] code);
    case (code)
      4'h8:    return OP_PRES;
      4'hC:    return OP_RDBIT;
      4'hE:    return OP_WRBIT;
      4'hD:    return OP_RDBYTE;
      4'hF:    return OP_WRBYTE;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic op_is_byte(input op_e op);
    return (op == OP_RDBYTE) || (op == OP_WRBYTE);
  endfunction

endpackage

// File: rtl/owh_tick.sv
module owh_tick #(
  parameter int CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLKS_PER_US);
      localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (clr)            div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/owh_slot.sv
module owh_slot
  import owh_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_SLOT  = 960,
  parameter int T_PRES_AT   = 70,
  parameter int T_SLOT      = 70,
  parameter int T_W1_LOW    = 6,
  parameter int T_W0_LOW    = 60,
  parameter int T_RD_LOW    = 6,
  parameter int T_RD_AT     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       line_s,
  output logic       busy,
  output logic       done,
  output logic       sample,
  output logic       drive_low
);
  localparam int UW = $clog2(T_RST_SLOT + T_SLOT + 1);

  function automatic logic [UW-1:0] low_len(input slot_kind_e k);
    case (k)
      SK_RESET: return UW'(T_RST_LOW);
      SK_WR0:   return UW'(T_W0_LOW);
      SK_WR1:   return UW'(T_W1_LOW);
      default:  return UW'(T_RD_LOW);
    endcase
  endfunction

  function automatic logic [UW-1:0] slot_len(input slot_kind_e k);
    return (k == SK_RESET) ? UW'(T_RST_SLOT) : UW'(T_SLOT);
  endfunction

  function automatic logic [UW-1:0] sample_at(input slot_kind_e k);
    case (k)
      SK_RESET: return UW'(T_RST_LOW + T_PRES_AT);
      SK_READ:  return UW'(T_RD_AT);
      default:  return '0;
    endcase
  endfunction

  logic           tick;
  logic [UW-1:0]  us_q;
  slot_kind_e     kind_q;
  logic           us_end;
  logic           us_sample;

  owh_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start | srst),
    .tick (tick)
  );

  assign us_end    = busy && tick && (us_q == slot_len(kind_q) - 1'b1);
  assign us_sample = busy && tick && ((us_q + 1'b1) == sample_at(kind_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sample <= 1'b1;
      us_q   <= '0;
      kind_q <= SK_READ;
    end else if (srst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sample <= 1'b1;
      us_q   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        us_q   <= '0;
        kind_q <= kind;
      end else if (busy && tick) begin
        us_q <= us_q + 1'b1;
        if (us_sample) sample <= line_s;
        if (us_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign drive_low = busy && (us_q < low_len(kind_q));

  a_r3_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !srst) |=> drive_low);

  a_r10_slot_abort: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !done));
endmodule

// File: rtl/owh_seq.sv
module owh_seq
  import owh_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 srst,
  input  logic                 go,
  input  op_e                  op,
  input  logic [BYTE_BITS-1:0] payload,
  input  logic                 slot_done,
  input  logic                 slot_bit,
  output logic                 slot_start,
  output slot_kind_e           slot_kind,
  output logic                 ready,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 nodev
);
  localparam int IW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_HOLD} st_e;

  st_e                  st_q;
  op_e                  op_q;
  logic                 go_prev;
  logic [IW-1:0]        idx_q;
  logic [BYTE_BITS-1:0] tx_q;
  logic [BYTE_BITS-1:0] rx_sh;
  logic                 go_rise;
  logic                 last_slot;

  assign go_rise   = go && !go_prev;
  assign last_slot = !op_is_byte(op_q) || (idx_q == LAST_BIT);

  always_comb begin
    case (op_q)
      OP_PRES:              slot_kind = SK_RESET;
      OP_RDBIT, OP_RDBYTE:  slot_kind = SK_READ;
      default:              slot_kind = tx_q[0] ? SK_WR1 : SK_WR0;
    endcase
  end

  assign slot_start = (st_q == S_ISSUE);
  assign ready      = (st_q == S_IDLE);
  assign done       = (st_q == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_NONE;
      go_prev <= 1'b0;
      idx_q   <= '0;
      tx_q    <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      nodev   <= 1'b0;
    end else begin
      go_prev <= go;
      if (srst) begin
        st_q    <= S_IDLE;
        idx_q   <= '0;
        rx_data <= '0;
        nodev   <= 1'b0;
      end else begin
        case (st_q)
          S_IDLE: if (go_rise) begin
            op_q  <= op;
            tx_q  <= payload;
            idx_q <= '0;
            st_q  <= (op == OP_NONE) ? S_HOLD : S_ISSUE;
          end
          S_ISSUE: st_q <= S_WAIT;
          S_WAIT: if (slot_done) begin
            case (op_q)
              OP_PRES:   nodev   <= slot_bit;
              OP_RDBIT:  rx_data <= BYTE_BITS'(slot_bit);
              OP_RDBYTE: begin
                rx_sh <= {slot_bit, rx_sh[BYTE_BITS-1:1]};
                if (last_slot) rx_data <= {slot_bit, rx_sh[BYTE_BITS-1:1]};
              end
              default:   tx_q <= tx_q >> 1;
            endcase
            if (last_slot) st_q <= S_HOLD;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_ISSUE;
            end
          end
          S_HOLD: if (!go) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && go && !srst) |=> done);

  a_r8_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go && !srst) |=> ready);

  a_r11_unknown_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && go_rise && !srst && op == OP_NONE) |=> (done && !slot_start));
endmodule

// File: rtl/owire_host.sv
module owire_host
  import owh_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_SLOT  = 960,
  parameter int T_PRES_AT   = 70,
  parameter int T_SLOT      = 70,
  parameter int T_W1_LOW    = 6,
  parameter int T_W0_LOW    = 60,
  parameter int T_RD_LOW    = 6,
  parameter int T_RD_AT     = 15,
  parameter int VER_MINOR   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq,
  output logic        line_oe,
  input  logic        line_in
);
  localparam int BYTE_BITS = 8;

  logic [11:0]          instr_q;
  logic                 go_q;
  logic                 srst_q;
  logic                 ien_done_q;
  logic                 ien_rdy_q;
  logic [1:0]           sync_q;
  logic                 wr_en;
  logic                 slot_start;
  slot_kind_e           slot_kind;
  logic                 slot_busy;
  logic                 slot_done;
  logic                 slot_bit;
  logic                 drive_low;
  logic                 ready;
  logic                 done;
  logic                 nodev;
  logic [BYTE_BITS-1:0] rx_data;
  logic [31:0]          rd_mux;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q    <= '0;
      go_q       <= 1'b0;
      srst_q     <= 1'b0;
      ien_done_q <= 1'b0;
      ien_rdy_q  <= 1'b0;
    end else if (wr_en) begin
      case (req_addr)
        A_INSTR: if (ready) instr_q <= req_wdata[11:0];
        A_CTRL: begin
          go_q   <= req_wdata[0];
          srst_q <= req_wdata[31];
        end
        A_IEN: begin
          ien_done_q <= req_wdata[0];
          ien_rdy_q  <= req_wdata[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end

  owh_seq #(.BYTE_BITS(BYTE_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst_q),
    .go        (go_q),
    .op        (decode_op(instr_q[11:8])),
    .payload   (instr_q[7:0]),
    .slot_done (slot_done),
    .slot_bit  (slot_bit),
    .slot_start(slot_start),
    .slot_kind (slot_kind),
    .ready     (ready),
    .done      (done),
    .rx_data   (rx_data),
    .nodev     (nodev)
  );

  owh_slot #(
    .CLKS_PER_US(CLKS_PER_US), .T_RST_LOW(T_RST_LOW), .T_RST_SLOT(T_RST_SLOT),
    .T_PRES_AT(T_PRES_AT), .T_SLOT(T_SLOT), .T_W1_LOW(T_W1_LOW),
    .T_W0_LOW(T_W0_LOW), .T_RD_LOW(T_RD_LOW), .T_RD_AT(T_RD_AT)
  ) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst_q),
    .start    (slot_start),
    .kind     (slot_kind),
    .line_s   (sync_q[1]),
    .busy     (slot_busy),
    .done     (slot_done),
    .sample   (slot_bit),
    .drive_low(drive_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_oe <= 1'b0;
    else        line_oe <= drive_low && !srst_q;
  end

  assign irq = (ien_done_q && done) || (ien_rdy_q && ready);

  always_comb begin
    case (req_addr)
      A_INSTR: rd_mux = {20'b0, instr_q};
      A_CTRL:  rd_mux = {srst_q, 30'b0, go_q};
      A_IEN:   rd_mux = {27'b0, ien_rdy_q, 3'b0, ien_done_q};
      A_STAT:  rd_mux = {nodev, 26'b0, ready, 3'b0, done};
      A_DATA:  rd_mux = {24'b0, rx_data};
      A_VER:   rd_mux = {8'b0, VER_MAJOR, 8'(VER_MINOR)};
      A_ID:    rd_mux = ID_WORD;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == A_IEN && req_wdata == 32'h0) |=> !irq);

  a_r10_line_release: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !line_oe);

  a_r12_instr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(instr_q));

  a_r8_slot_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy |-> !ready);
endmodule

// File: tb/owire_host_bench.sv
module owire_host_bench;
  localparam int C = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq, line_oe;
  logic [31:0] rsp_rdata;
  logic        dev_pull = 1'b0;
  logic        line_in;

  int passed = 0;
  int total  = 0;

  // device model state
  logic        dev_present = 1'b1;
  logic [7:0]  rd_bits = 8'hFF;
  int          rd_base = 0;
  int          dev_f = 0;
  int          dev_n = 0;
  int          lens [256];
  int          low_cnt = 0;
  int          pull_cnt = 0;
  int          pres_wait = 0;
  logic        prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign line_in = ~(line_oe | dev_pull);

  owire_host #(.CLKS_PER_US(C), .VER_MINOR(3)) u_owire_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
    .line_oe(line_oe), .line_in(line_in)
  );

  always @(posedge clk) begin
    if (line_oe && !prev_oe) begin
      low_cnt = 0;
      if (!rd_bits[(dev_f - rd_base) & 7]) pull_cnt = 30 * C;
      dev_f++;
    end
    if (line_oe) low_cnt++;
    if (!line_oe && prev_oe) begin
      lens[dev_n & 255] = low_cnt;
      dev_n++;
      if (low_cnt == 480 * C && dev_present) pres_wait = 15 * C;
    end
    if (pres_wait > 0) begin
      pres_wait--;
      if (pres_wait == 0) pull_cnt = 120 * C;
    end
    if (pull_cnt > 0) begin
      pull_cnt--;
      dev_pull <= 1'b1;
    end else dev_pull <= 1'b0;
    prev_oe = line_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    if (!rsp_valid) chk(1'b0, "R13 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 6000 && !s[0]; i++) bus_read(5'h0C, s);
    chk(s[0] && !s[4], {tag, " done set, ready low"}, s, {s[31], 31'h1});
  endtask

  task automatic run_op(input logic [31:0] instr, input string tag);
    bus_write(5'h00, instr);
    bus_write(5'h04, 32'h1);
    wait_done(tag);
  endtask

  function automatic logic [7:0] decode_written(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = (lens[(base + i) & 255] == 6 * C);
    return b;
  endfunction

  task automatic t_reset_state;
    logic [31:0] d;
    bus_read(5'h0C, d);
    chk(d == 32'h10, "R2 status after reset", d, 32'h10);
    chk(!line_oe && !irq, "R2 line released, irq low", {line_oe, irq}, 32'h0);
    bus_read(5'h1C, d);
    chk(d == 32'h10EE4453, "R1 identification", d, 32'h10EE4453);
    bus_read(5'h18, d);
    chk(d == 32'h0000_0103, "R1 version major 1 minor 3", d, 32'h0000_0103);
    chk(req_ready, "R13 req_ready high", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic t_presence;
    logic [31:0] d;
    int base;
    rd_bits = 8'hFF; dev_present = 1'b1; base = dev_n;
    run_op(32'h0800, "R3 present");
    bus_read(5'h0C, d);
    chk(!d[31], "R3 device answered", d, 32'h1);
    chk(lens[base & 255] == 480 * C, "R3 reset low length", lens[base & 255], 480 * C);
    bus_write(5'h04, 32'h0);
    dev_present = 1'b0;
    run_op(32'h0800, "R3 absent");
    bus_read(5'h0C, d);
    chk(d[31], "R3 no device flag", d, 32'h8000_0001);
    bus_write(5'h04, 32'h0);
    dev_present = 1'b1;
  endtask

  task automatic t_write_bit;
    int base;
    base = dev_n;
    run_op(32'h0E01, "R4 write 1");
    bus_write(5'h04, 32'h0);
    run_op(32'h0E00, "R4 write 0");
    bus_write(5'h04, 32'h0);
    chk(lens[base & 255] == 6 * C, "R4 write-1 low", lens[base & 255], 6 * C);
    chk(lens[(base + 1) & 255] == 60 * C, "R4 write-0 low", lens[(base + 1) & 255], 60 * C);
  endtask

  task automatic t_read_bit;
    logic [31:0] d;
    int base;
    base = dev_n; rd_base = dev_f; rd_bits = 8'hFE;
    run_op(32'h0C00, "R5 read 0");
    bus_read(5'h10, d);
    chk(d == 32'h0, "R5 read bit 0", d, 32'h0);
    bus_write(5'h04, 32'h0);
    rd_base = dev_f; rd_bits = 8'hFF;
    run_op(32'h0C00, "R5 read 1");
    bus_read(5'h10, d);
    chk(d == 32'h1, "R5 read bit 1", d, 32'h1);
    bus_write(5'h04, 32'h0);
    chk(lens[base & 255] == 6 * C, "R5 read slot low", lens[base & 255], 6 * C);
  endtask

  task automatic t_write_byte_locked;
    int base;
    logic [7:0] b;
    base = dev_n; rd_bits = 8'hFF;
    bus_write(5'h00, 32'h0FA5);
    bus_write(5'h04, 32'h1);
    repeat (300) @(negedge clk);
    bus_write(5'h00, 32'h0F3C);   // R12: must be ignored
    wait_done("R6 write byte");
    bus_write(5'h04, 32'h0);
    b = decode_written(base);
    chk(dev_n - base == 8, "R6 eight slots", dev_n - base, 8);
    chk(b == 8'hA5, "R6 R12 byte LSB first, payload kept", {24'b0, b}, 32'hA5);
  endtask

  task automatic t_read_byte;
    logic [31:0] d;
    rd_base = dev_f; rd_bits = 8'h3C;
    run_op(32'h0D00, "R7 read byte");
    bus_read(5'h10, d);
    chk(d == 32'h3C, "R7 received byte", d, 32'h3C);
    bus_write(5'h04, 32'h0);
    rd_bits = 8'hFF;
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    bus_write(5'h00, 32'h0E01);
    bus_write(5'h04, 32'h1);
    bus_read(5'h0C, d);
    chk(d[4:0] == 5'h0, "R8 ready low while running", d, 32'h0);
    wait_done("R8");
    repeat (20) @(negedge clk);
    bus_read(5'h0C, d);
    chk(d[4:0] == 5'h01, "R8 done held while GO high", d, 32'h1);
    bus_write(5'h04, 32'h0);
    bus_read(5'h0C, d);
    chk(d[4:0] == 5'h10, "R8 done cleared, ready back", d, 32'h10);
  endtask

  task automatic t_irq;
    bus_write(5'h08, 32'h10);
    @(negedge clk);
    chk(irq, "R9 ready interrupt", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h01);
    @(negedge clk);
    chk(!irq, "R9 done interrupt quiet while idle", {31'b0, irq}, 32'h0);
    run_op(32'h0E01, "R9");
    chk(irq, "R9 done interrupt", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h0);
    chk(!irq, "R9 cleared by enable write", {31'b0, irq}, 32'h0);
    bus_write(5'h04, 32'h0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    int n0;
    rd_base = dev_f; rd_bits = 8'h5A;
    run_op(32'h0D00, "R10 setup");
    bus_write(5'h04, 32'h0);
    dev_present = 1'b0;
    run_op(32'h0800, "R10 setup nodev");
    bus_write(5'h04, 32'h0);
    dev_present = 1'b1; rd_bits = 8'hFF;
    bus_write(5'h00, 32'h0F00);
    bus_write(5'h04, 32'h1);
    repeat (10) @(negedge clk);
    bus_write(5'h04, 32'h8000_0000);
    @(negedge clk);
    chk(!line_oe, "R10 line released", {31'b0, line_oe}, 32'h0);
    bus_read(5'h0C, d);
    chk(d == 32'h10, "R10 ready, flags cleared", d, 32'h10);
    bus_read(5'h10, d);
    chk(d == 32'h0, "R10 data cleared", d, 32'h0);
    n0 = dev_f;
    bus_write(5'h04, 32'h8000_0001);
    repeat (50) @(negedge clk);
    bus_write(5'h04, 32'h1);
    repeat (50) @(negedge clk);
    bus_read(5'h0C, d);
    chk(d == 32'h10 && dev_f == n0, "R10 GO with reset starts nothing", d, 32'h10);
    bus_write(5'h04, 32'h0);
  endtask

  task automatic t_unknown;
    logic [31:0] d;
    int n0;
    n0 = dev_f;
    bus_write(5'h00, 32'h0300);
    bus_write(5'h04, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(5'h0C, d);
    chk(d[4:0] == 5'h01, "R11 unknown opcode done", d, 32'h1);
    chk(dev_f == n0 && !line_oe, "R11 no line activity", dev_f - n0, 0);
    bus_write(5'h04, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_presence();
    t_write_bit();
    t_read_bit();
    t_write_byte_locked();
    t_read_byte();
    t_handshake();
    t_irq();
    t_soft_reset();
    t_unknown();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule